// File: doc/BRIEF.md
# Flash device command interpreter

This block is a synthesizable behavioural model of the command state machine found inside a single 16-bit NOR flash device. A host writes command bytes on the low byte of the data bus. The last accepted command decides what a read returns: the array contents, the identifier codes or the status byte. Erase, single-word programming, buffered programming and per-block lock bits are modelled. Each operation holds the device busy for a configurable number of clock cycles. Errors are reported through sticky status bits that only a dedicated command clears.

The array is `NUM_BLOCKS` blocks of `BLOCK_WORDS` 16-bit words, and every word is erased (0xFFFF) after reset. The defaults are kept small so that the model elaborates quickly. A real device has 0x20000-byte blocks and a 0x20- or 0x40-byte write buffer, and the parameters can be scaled to match. Reads are combinational from registered state and the array, so a read reflects a write from the cycle after the edge that captured it.

The sequence states are as follows. `S_READY` takes top-level commands. From it, 0x20 leads to `S_ERASE_CONF`, 0x60 to `S_LOCK_CONF`, 0x40 to `S_WORD_DATA` and 0xE8 to `S_BUF_COUNT`. `S_BUF_COUNT` goes to `S_BUF_DATA` on a legal count and back to `S_READY` on an oversized one. `S_BUF_DATA` stays put until the last word arrives and then goes to `S_BUF_CONF`. Every confirm or data state returns to `S_READY` after one accepted write. The read selector is one of `RD_ARRAY`, `RD_IDENT` or `RD_STATUS`.

Top module: `flash_cmd_model`

## Requirements
- R1: After reset the read selector is array mode, every word reads 0xFFFF, no block is locked, and the status byte reads 0x80.
- R2: Only bits [7:0] of a command write are decoded. 0xFF selects array reads. 0x90 selects identifier reads, where word offset 0 within a block returns 0x0089, offset 1 returns `DEVICE_CODE` (default 0x0018), and any other offset returns 0. 0x70 selects status reads, which return {8'h00, status}. The status bits are: 7 ready, 5 erase error, 4 program error, 1 block locked; bits 6, 3, 2 and 0 read 0.
- R3: Command 0x50 in `S_READY` clears status bits 5, 4 and 1 and leaves the read selector unchanged.
- R4: 0x20 followed by 0xD0 sets every word of the block addressed by the confirm write to 0xFFFF and leaves other blocks unchanged. Any command that opens a sequence (0x20, 0x60, 0x40, 0xE8) switches reads to status.
- R5: 0x40 followed by a data write replaces the addressed word with the old value ANDed with the data.
- R6: After 0xE8, the next write's low byte is N-1 with N ≤ `BUF_WORDS`. N data writes follow, then 0xD0. The first data write's address sets the start, and word i is ANDed into the word at block offset (start offset + i) mod `BLOCK_WORDS` of the start's block.
- R7: Each of the following sets status bits 5 and 4 and changes no array word or lock bit: a buffer count with N-1 ≥ `BUF_WORDS`; a value other than 0xD0 after 0x20 or in the buffer confirm step; a value other than 0xD0 or 0x01 after 0x60.
- R8: 0x60 followed by 0x01 sets the lock bit of the addressed block, and 0x60 followed by 0xD0 clears it.
- R9: An erase aimed at a locked block sets bits 5 and 1, and a word or buffer program aimed at one sets bits 4 and 1. In both cases the array stays unchanged.
- R10: Every erase, program or lock commit makes bit 7 read 0 for exactly `BUSY_CYCLES` cycles after the commit edge. Writes during that window are ignored.
- R11: The error bits are sticky: successful operations never clear them, and only 0x50 does.
- R12: Unrecognised command bytes written in `S_READY` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, captured at the rising edge |
| addr | input | ADDR_W (6) | Word address |
| wdata | input | 16 | Write data; bits [7:0] carry commands |
| rdata | output | 16 | Read data chosen by the read selector |

## Verification
A write is captured at a rising edge, and its effect on `rdata` (mode, status or array word) is visible from one clock after that edge. The ready bit drops right after a commit edge and returns exactly `BUSY_CYCLES` edges later. The bench model applies each write at the same rising edge the design does and compares `rdata` at every falling edge. Literal spot checks are taken 1 ns after a rising edge: one immediately after a commit, one at edge `BUSY_CYCLES`-1 and one at edge `BUSY_CYCLES`. This pins the busy window to the exact cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        S_READY,
        S_ERASE_CONF,
        S_LOCK_CONF,
        S_WORD_DATA,
        S_BUF_COUNT,
        S_BUF_DATA,
        S_BUF_CONF
    } seq_state_e;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_IDENT,
        RD_STATUS
    } rd_mode_e;

    localparam logic [7:0] OP_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_READ_IDENT   = 8'h90;
    localparam logic [7:0] OP_READ_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] OP_ERASE        = 8'h20;
    localparam logic [7:0] OP_LOCK         = 8'h60;
    localparam logic [7:0] OP_LOCK_SET     = 8'h01;
    localparam logic [7:0] OP_WORD_PROG    = 8'h40;
    localparam logic [7:0] OP_BUF_PROG     = 8'hE8;
    localparam logic [7:0] OP_CONFIRM      = 8'hD0;

    localparam logic [15:0] VENDOR_CODE    = 16'h0089;

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int BUSY_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CW'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);

    // R10: a commit always opens a busy window
    a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_WORDS = 16,
    parameter int BUF_WORDS   = 8,
    localparam int BW = $clog2(BLOCK_WORDS),
    localparam int NW = NUM_BLOCKS * BLOCK_WORDS,
    localparam int AW = $clog2(NW),
    localparam int IW = $clog2(BUF_WORDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         erase_i,
    input  logic                         prog_word_i,
    input  logic                         prog_buf_i,
    input  logic                         lock_set_i,
    input  logic                         lock_clr_i,
    input  logic [AW-1:0]                op_addr_i,
    input  logic [15:0]                  word_data_i,
    input  logic [BUF_WORDS-1:0][15:0]   buf_data_i,
    input  logic [IW-1:0]                buf_last_i,
    input  logic [AW-1:0]                rd_addr_i,
    output logic [15:0]                  rd_word_o,
    output logic                         op_locked_o
);
    logic [15:0]           mem_q [NW];
    logic [NUM_BLOCKS-1:0] lock_q;
    logic [AW-BW-1:0]      op_blk;
    logic [BW-1:0]         op_off;

    assign op_blk      = op_addr_i[AW-1:BW];
    assign op_off      = op_addr_i[BW-1:0];
    assign op_locked_o = lock_q[op_blk];
    assign rd_word_o   = mem_q[rd_addr_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NW; n++) begin
                mem_q[n] <= 16'hFFFF;
            end
            lock_q <= '0;
        end else begin
            if (erase_i && !lock_q[op_blk]) begin
                for (int w = 0; w < BLOCK_WORDS; w++) begin
                    mem_q[{op_blk, BW'(w)}] <= 16'hFFFF;
                end
            end
            if (prog_word_i && !lock_q[op_blk]) begin
                mem_q[op_addr_i] <= mem_q[op_addr_i] & word_data_i;
            end
            if (prog_buf_i && !lock_q[op_blk]) begin
                for (int i = 0; i < BUF_WORDS; i++) begin
                    if (IW'(i) <= buf_last_i) begin
                        mem_q[{op_blk, op_off + BW'(i)}] <=
                            mem_q[{op_blk, op_off + BW'(i)}] & buf_data_i[i];
                    end
                end
            end
            if (lock_set_i) begin
                lock_q[op_blk] <= 1'b1;
            end else if (lock_clr_i) begin
                lock_q[op_blk] <= 1'b0;
            end
        end
    end

    // R5: programming can only clear bits of the target word
    a_r5_prog_clears_only: assert property (@(posedge clk) disable iff (!rst_n)
        prog_word_i |=> ((mem_q[$past(op_addr_i)] & ~$past(mem_q[op_addr_i])) == 16'h0000));

    // R9: a program aimed at a locked block leaves the word intact
    a_r9_locked_intact: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_word_i && op_locked_o) |=> (mem_q[$past(op_addr_i)] == $past(mem_q[op_addr_i])));

    // R4: an accepted erase leaves the addressed word erased
    a_r4_erase_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_i && !op_locked_o) |=> (mem_q[$past(op_addr_i)] == 16'hFFFF));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW        = 6,
    parameter int BUF_WORDS = 8,
    localparam int IW = $clog2(BUF_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [15:0]                 wdata_i,
    input  logic                        busy_i,
    input  logic                        locked_i,
    output rd_mode_e                    mode_o,
    output logic [7:0]                  status_o,
    output logic                        erase_o,
    output logic                        prog_word_o,
    output logic                        prog_buf_o,
    output logic                        lock_set_o,
    output logic                        lock_clr_o,
    output logic                        start_o,
    output logic [AW-1:0]               op_addr_o,
    output logic [BUF_WORDS-1:0][15:0]  buf_data_o,
    output logic [IW-1:0]               buf_last_o
);
    seq_state_e state_q, state_d;
    rd_mode_e   mode_q;
    logic       erase_err_q, prog_err_q, lock_err_q;
    logic [IW-1:0]              last_q, fill_q;
    logic [AW-1:0]              start_q;
    logic [BUF_WORDS-1:0][15:0] buf_q;
    logic       acc, seq_err, clear_cmd;
    logic [7:0] cmd;

    assign acc       = wr_en_i && !busy_i;
    assign cmd       = wdata_i[7:0];
    assign clear_cmd = acc && (state_q == S_READY) && (cmd == OP_CLEAR_STATUS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_READY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (acc) begin
            unique case (state_q)
                S_READY: begin
                    case (cmd)
                        OP_ERASE:     state_d = S_ERASE_CONF;
                        OP_LOCK:      state_d = S_LOCK_CONF;
                        OP_WORD_PROG: state_d = S_WORD_DATA;
                        OP_BUF_PROG:  state_d = S_BUF_COUNT;
                        default:      state_d = S_READY;
                    endcase
                end
                S_BUF_COUNT: state_d = (int'(cmd) < BUF_WORDS) ? S_BUF_DATA : S_READY;
                S_BUF_DATA:  state_d = (fill_q == last_q) ? S_BUF_CONF : S_BUF_DATA;
                S_ERASE_CONF, S_LOCK_CONF, S_WORD_DATA, S_BUF_CONF: state_d = S_READY;
                default:     state_d = S_READY;
            endcase
        end
    end

    // outputs: operation strobes
    always_comb begin
        erase_o     = acc && (state_q == S_ERASE_CONF) && (cmd == OP_CONFIRM);
        lock_clr_o  = acc && (state_q == S_LOCK_CONF)  && (cmd == OP_CONFIRM);
        lock_set_o  = acc && (state_q == S_LOCK_CONF)  && (cmd == OP_LOCK_SET);
        prog_word_o = acc && (state_q == S_WORD_DATA);
        prog_buf_o  = acc && (state_q == S_BUF_CONF)   && (cmd == OP_CONFIRM);
        seq_err     = acc && (((state_q == S_ERASE_CONF) && (cmd != OP_CONFIRM)) ||
                              ((state_q == S_LOCK_CONF)  && (cmd != OP_CONFIRM) && (cmd != OP_LOCK_SET)) ||
                              ((state_q == S_BUF_COUNT)  && (int'(cmd) >= BUF_WORDS)) ||
                              ((state_q == S_BUF_CONF)   && (cmd != OP_CONFIRM)));
        start_o     = erase_o || lock_clr_o || lock_set_o || prog_word_o || prog_buf_o;
        op_addr_o   = (state_q == S_BUF_CONF) ? start_q : addr_i;
    end

    // read selector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= RD_ARRAY;
        end else if (acc && state_q == S_READY) begin
            case (cmd)
                OP_READ_ARRAY:  mode_q <= RD_ARRAY;
                OP_READ_IDENT:  mode_q <= RD_IDENT;
                OP_READ_STATUS, OP_ERASE, OP_LOCK,
                OP_WORD_PROG, OP_BUF_PROG: mode_q <= RD_STATUS;
                default:        mode_q <= mode_q;
            endcase
        end
    end

    // sticky error bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_err_q <= 1'b0;
            prog_err_q  <= 1'b0;
            lock_err_q  <= 1'b0;
        end else if (clear_cmd) begin
            erase_err_q <= 1'b0;
            prog_err_q  <= 1'b0;
            lock_err_q  <= 1'b0;
        end else begin
            if (seq_err) begin
                erase_err_q <= 1'b1;
                prog_err_q  <= 1'b1;
            end
            if (erase_o && locked_i) begin
                erase_err_q <= 1'b1;
                lock_err_q  <= 1'b1;
            end
            if ((prog_word_o || prog_buf_o) && locked_i) begin
                prog_err_q <= 1'b1;
                lock_err_q <= 1'b1;
            end
        end
    end

    // write buffer collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q  <= '0;
            fill_q  <= '0;
            start_q <= '0;
            buf_q   <= '0;
        end else if (acc && state_q == S_BUF_COUNT) begin
            last_q <= cmd[IW-1:0];
            fill_q <= '0;
        end else if (acc && state_q == S_BUF_DATA) begin
            buf_q[fill_q] <= wdata_i;
            if (fill_q == '0) start_q <= addr_i;
            fill_q <= fill_q + 1'b1;
        end
    end

    assign mode_o     = mode_q;
    assign status_o   = {!busy_i, 1'b0, erase_err_q, prog_err_q, 1'b0, 1'b0, lock_err_q, 1'b0};
    assign buf_data_o = buf_q;
    assign buf_last_o = last_q;

    // R10: while busy, no sequence can be open (writes are ignored)
    a_r10_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (state_q == S_READY));

    // R11: an error bit only falls after a clear command
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(prog_err_q) || $fell(erase_err_q) || $fell(lock_err_q)) |-> $past(clear_cmd));

endmodule

// File: rtl/flash_cmd_model.sv
module flash_cmd_model
    import flash_cmd_pkg::*;
#(
    parameter int          NUM_BLOCKS  = 4,
    parameter int          BLOCK_WORDS = 16,
    parameter int          BUF_WORDS   = 8,
    parameter int          BUSY_CYCLES = 5,
    parameter logic [15:0] DEVICE_CODE = 16'h0018,
    localparam int BW     = $clog2(BLOCK_WORDS),
    localparam int ADDR_W = $clog2(NUM_BLOCKS * BLOCK_WORDS),
    localparam int IW     = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    rd_mode_e                   mode;
    logic [7:0]                 status;
    logic                       busy, locked, start;
    logic                       erase, prog_word, prog_buf, lock_set, lock_clr;
    logic [ADDR_W-1:0]          op_addr;
    logic [BUF_WORDS-1:0][15:0] buf_data;
    logic [IW-1:0]              buf_last;
    logic [15:0]                array_word;

    flash_cmd_fsm #(.AW(ADDR_W), .BUF_WORDS(BUF_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .busy_i(busy), .locked_i(locked), .mode_o(mode), .status_o(status),
        .erase_o(erase), .prog_word_o(prog_word), .prog_buf_o(prog_buf),
        .lock_set_o(lock_set), .lock_clr_o(lock_clr), .start_o(start),
        .op_addr_o(op_addr), .buf_data_o(buf_data), .buf_last_o(buf_last)
    );

    flash_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy)
    );

    flash_cell_array #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS),
                       .BUF_WORDS(BUF_WORDS)) u_array (
        .clk(clk), .rst_n(rst_n), .erase_i(erase), .prog_word_i(prog_word),
        .prog_buf_i(prog_buf), .lock_set_i(lock_set), .lock_clr_i(lock_clr),
        .op_addr_i(op_addr), .word_data_i(wdata), .buf_data_i(buf_data),
        .buf_last_i(buf_last), .rd_addr_i(addr), .rd_word_o(array_word),
        .op_locked_o(locked)
    );

    always_comb begin
        unique case (mode)
            RD_ARRAY:  rdata = array_word;
            RD_IDENT:  begin
                if (addr[BW-1:0] == BW'(0))      rdata = VENDOR_CODE;
                else if (addr[BW-1:0] == BW'(1)) rdata = DEVICE_CODE;
                else                             rdata = 16'h0000;
            end
            RD_STATUS: rdata = {8'h00, status};
            default:   rdata = 16'h0000;
        endcase
    end

endmodule

// File: tb/tb_flash_cmd_model.sv
`timescale 1ns/1ps
module tb_flash_cmd_model;
    localparam int NB = 4, BWD = 16, BUFW = 8, BUSY = 5, DEV = 16'h0018;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0, errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    flash_cmd_model dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                         .wdata(wdata), .rdata(rdata));

    // ---------------- behavioural reference ----------------
    int m_mem [NB*BWD];
    int m_lk [NB];
    int m_mode, m_seq, m_busy, m_e, m_p, m_l, m_len, m_start;
    int m_q [$];

    task automatic m_reset();
        foreach (m_mem[i]) m_mem[i] = 'hFFFF;
        foreach (m_lk[i]) m_lk[i] = 0;
        m_mode = 0; m_seq = 0; m_busy = 0; m_e = 0; m_p = 0; m_l = 0;
        m_q.delete();
    endtask

    task automatic m_write(input int a, input int d);
        int c, blk, sb;
        c = d & 'hFF;
        blk = a / BWD;
        case (m_seq)
            0: begin
                if (c == 'hFF) m_mode = 0;
                else if (c == 'h90) m_mode = 1;
                else if (c == 'h70) m_mode = 2;
                else if (c == 'h50) begin m_e = 0; m_p = 0; m_l = 0; end
                else if (c == 'h20) begin m_seq = 1; m_mode = 2; end
                else if (c == 'h60) begin m_seq = 2; m_mode = 2; end
                else if (c == 'h40) begin m_seq = 3; m_mode = 2; end
                else if (c == 'hE8) begin m_seq = 4; m_mode = 2; end
            end
            1: begin
                if (c == 'hD0) begin
                    if (m_lk[blk] != 0) begin m_e = 1; m_l = 1; end
                    else for (int w = 0; w < BWD; w++) m_mem[blk*BWD + w] = 'hFFFF;
                    m_busy = BUSY;
                end else begin m_e = 1; m_p = 1; end
                m_seq = 0;
            end
            2: begin
                if (c == 'hD0) begin m_lk[blk] = 0; m_busy = BUSY; end
                else if (c == 'h01) begin m_lk[blk] = 1; m_busy = BUSY; end
                else begin m_e = 1; m_p = 1; end
                m_seq = 0;
            end
            3: begin
                if (m_lk[blk] != 0) begin m_p = 1; m_l = 1; end
                else m_mem[a] = m_mem[a] & d;
                m_busy = BUSY;
                m_seq = 0;
            end
            4: begin
                if (c < BUFW) begin m_len = c + 1; m_q.delete(); m_seq = 5; end
                else begin m_e = 1; m_p = 1; m_seq = 0; end
            end
            5: begin
                if (m_q.size() == 0) m_start = a;
                m_q.push_back(d);
                if (m_q.size() == m_len) m_seq = 6;
            end
            default: begin
                if (c == 'hD0) begin
                    sb = m_start / BWD;
                    if (m_lk[sb] != 0) begin m_p = 1; m_l = 1; end
                    else foreach (m_q[i])
                        m_mem[sb*BWD + ((m_start % BWD) + i) % BWD] &= m_q[i];
                    m_busy = BUSY;
                end else begin m_e = 1; m_p = 1; end
                m_seq = 0;
            end
        endcase
    endtask

    function automatic int m_read(input int a);
        int off;
        off = a % BWD;
        if (m_mode == 0) return m_mem[a];
        if (m_mode == 1) return (off == 0) ? 'h89 : (off == 1) ? DEV : 0;
        return ((m_busy == 0) ? 'h80 : 0) | (m_e << 5) | (m_p << 4) | (m_l << 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            bit acc;
            acc = wr_en && (m_busy == 0);
            if (m_busy > 0) m_busy--;
            if (acc) m_write(int'(addr), int'(wdata));
        end
    end

    // ---------------- checking ----------------
    task automatic check(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) check(int'(rdata), m_read(int'(addr)), cur_tag);
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a[5:0]; wdata = d[15:0];
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic peek(input int a, input int exp, input string tag);
        @(posedge clk); #1;
        addr = a[5:0];
        #1;
        check(int'(rdata), exp, tag);
    endtask

    task automatic wait_ready();
        repeat (BUSY + 1) @(posedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_tag = "R1";
        peek(0, 'hFFFF, "R1 erased after reset");
        peek(63, 'hFFFF, "R1 erased after reset");
        wr(0, 'h70);
        peek(0, 'h0080, "R1 status after reset");

        cur_tag = "R2";
        wr(0, 'hAB90);                                // upper byte ignored
        peek(0, 'h0089, "R2 vendor code");
        peek(17, 'h0018, "R2 device code");
        peek(2, 'h0000, "R2 other offset");
        wr(0, 'h12FF);
        peek(7, 'hFFFF, "R2 back to array");

        cur_tag = "R12";
        wr(0, 'h33);
        peek(7, 'hFFFF, "R12 unknown command ignored");

        cur_tag = "R5";
        wr(0, 'h40); wr(3, 'h1234);
        #1 addr = 6'd3; #1;
        check(int'(rdata), 'h0000, "R10 busy right after commit");
        wr(0, 'hFF);                                  // during busy: ignored
        wait_ready();
        peek(3, 'h0080, "R10 write during busy ignored");
        wr(0, 'hFF);
        peek(3, 'h1234, "R5 word programmed");
        wr(0, 'h40); wr(3, 'hFF0F);
        repeat (BUSY - 1) @(posedge clk); #1;
        check(int'(rdata), 'h0000, "R10 still busy at last cycle");
        @(posedge clk); #1;
        check(int'(rdata), 'h0080, "R10 ready after window");
        wr(0, 'hFF);
        peek(3, 'h1204, "R5 program ANDs");

        cur_tag = "R6";
        wr(20, 'hE8);
        peek(20, 'h0080, "R6 status after buffer command");
        wr(20, 3);
        wr(20, 'h1111); wr(21, 'h2222); wr(22, 'h3333); wr(23, 'h4444);
        wr(20, 'hD0); wait_ready(); wr(0, 'hFF);
        peek(20, 'h1111, "R6 buffer word 0");
        peek(23, 'h4444, "R6 buffer word 3");
        wr(46, 'hE8); wr(46, 3);
        wr(46, 'hA5A5); wr(46, 'h5A5A); wr(46, 'h0F0F); wr(46, 'hF0F0);
        wr(46, 'hD0); wait_ready(); wr(0, 'hFF);
        peek(47, 'h5A5A, "R6 buffer before wrap");
        peek(32, 'h0F0F, "R6 buffer wraps in block");
        peek(33, 'hF0F0, "R6 buffer wraps in block");
        peek(34, 'hFFFF, "R6 buffer length honoured");

        cur_tag = "R7";
        wr(0, 'hE8); wr(0, 8);
        peek(0, 'h00B0, "R7 oversize count");
        wr(0, 'h50);
        peek(0, 'h0080, "R3 clear status");
        wr(0, 'h20); wr(0, 'h77);
        peek(0, 'h00B0, "R7 bad erase confirm");
        wr(0, 'h50);
        wr(0, 'h60); wr(0, 'h42);
        peek(0, 'h00B0, "R7 bad lock confirm");
        wr(0, 'h50); wr(0, 'hFF);
        peek(3, 'h1204, "R7 array untouched");

        cur_tag = "R9";
        wr(0, 'h60); wr(0, 'h01); wait_ready();       // R8 lock block 0
        wr(0, 'h20); wr(0, 'hD0); wait_ready();
        peek(0, 'h00A2, "R9 erase of locked block");
        wr(5, 'h40); wr(5, 'h0000); wait_ready();
        peek(0, 'h00B2, "R9 program of locked block");
        wr(0, 'hFF);
        peek(3, 'h1204, "R8 lock kept erase out");
        peek(5, 'hFFFF, "R9 locked word unchanged");

        cur_tag = "R11";
        wr(0, 'h60); wr(0, 'hD0); wait_ready();       // R8 unlock
        wr(0, 'h20); wr(0, 'hD0); wait_ready();
        peek(0, 'h00B2, "R11 errors sticky after success");
        wr(0, 'hFF);
        peek(3, 'hFFFF, "R8 unlocked block erased");
        wr(0, 'h50); wr(0, 'h70);
        peek(0, 'h0080, "R3 clear restores");

        cur_tag = "R4";
        wr(20, 'h20); wr(25, 'hD0); wait_ready(); wr(0, 'hFF);
        peek(20, 'hFFFF, "R4 block erased");
        peek(23, 'hFFFF, "R4 block erased");
        peek(46, 'hA5A5, "R4 other block kept");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule